// File: doc/BRIEF.md
# Synchronous Serial Port Register Front End

This block is the bus-facing half of a synchronous serial port. A processor reaches it through a simple word-addressed bus inside a 4 KB window. Through that bus the processor sets the frame size and the port mode, writes words to send and reads words that came back. It can also read level flags, set a four-bit interrupt enable, and read a fixed eight-byte identification block at the top of the window. The serial pin timing is handled by a separate transfer engine. That engine takes words from the transmit queue through a pop port and hands received words to the receive queue through a push port.

Both queues are 8 entries of 16 bits. Status flags and one combined interrupt line come straight from the two queue levels. The receive interrupt fires once the receive queue is half full, and the transmit interrupt fires once the transmit queue has drained to half or less. A write that finds the transmit queue full is lost without notice. A read that finds the receive queue empty returns zero and removes nothing. Any access to an offset that decodes to nothing returns zero, changes nothing and raises a one-cycle error strobe.

Read data is combinational: `bus_rdata` is valid in the same cycle as `bus_en` with `bus_we` low, and it is zero at every other time. Register writes, queue pushes and queue pops all take effect at the next rising clock edge.

Top module: `ssp_regfile`

## Requirements
- R1: The frame control register at offset 0x000 (16 bits), the mode register at 0x004 (4 bits), the clock divider at 0x010 (low 8 bits kept) and the interrupt enable at 0x014 (4 bits) read back the values last written. `port_mode` always shows the mode register, with bit 0 loopback, bit 1 port enable, bit 2 slave select and bit 3 slave output disable.
- R2: A write to the data register at 0x008 appends `wdata & ((2^(n+1))-1)` to the transmit queue, where n is bits [3:0] of the frame control register. The queue then presents its words in first-in first-out order on `tx_data`, with `tx_valid` high while the queue is not empty. Each `tx_pop` pulse removes one word.
- R3: A data register write while the transmit queue holds 8 words is discarded, even if `tx_pop` is asserted in the same cycle.
- R4: A read of 0x008 returns the oldest receive word and removes it. If the receive queue is empty, the read returns 0 and removes nothing. `rx_push` adds `rx_data` unless the queue holds 8 words, and `rx_ready` is high while fewer than 8 words are held.
- R5: The status register at 0x00C reads as follows: bit 0 is high when the transmit queue is empty, bit 1 when it is not full, bit 2 when the receive queue is not empty, bit 3 when the receive queue is full, and bit 4 (busy) whenever the transmit queue holds any word. All other bits read 0.
- R6: The raw interrupt register at 0x018 has bit 2 set when the receive queue holds 4 or more words and bit 3 set when the transmit queue holds 4 or fewer. Its other bits are 0. The register at 0x01C reads the enable AND the raw value.
- R7: `irq` is high exactly when the enable AND the raw interrupt value is nonzero.
- R8: Aligned reads at 0xFE0 through 0xFFC return, in address order, the bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, each in the low 8 bits.
- R9: Any offset other than those above, including any offset with bits [1:0] nonzero, reads 0 and ignores writes, and `bus_err` is high for exactly the one cycle after such an access. The transfer control word at 0x020 reads 0 and accepts writes without effect or error. Writes to the read-only registers (status, raw, masked and the identification block) are ignored without error.
- R10: After reset both queues are empty, the enable and all registers are 0, status reads 0x03, raw interrupt reads 0x08, and `irq` and `bus_err` are low.
- R11: A push and a pop on the same queue in the same cycle both take effect when the queue is neither empty nor full, and the level then stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset inside the 4 KB window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when not reading |
| bus_err | output | 1 | One-cycle strobe after an access to an undecoded offset |
| irq | output | 1 | Combined interrupt |
| port_mode | output | 4 | Mode register contents for the transfer engine |
| tx_pop | input | 1 | Engine removes the head of the transmit queue |
| tx_data | output | 16 | Head of the transmit queue (0 when empty) |
| tx_valid | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Engine appends `rx_data` to the receive queue |
| rx_data | input | 16 | Received word |
| rx_ready | output | 1 | Receive queue has room |

## Verification
The queues are tested with separate patterns, and each one separates a different failure. Filling the transmit queue to nine writes with no pops shows whether the ninth write is dropped. Pushing nine received words and then reading ten shows both the full limit and the zero returned by an empty read. Same-cycle pushes and pops at levels 0, 4 and 8 separate correct counting from off-by-one and full/empty mistakes. Several frame sizes show whether the mask width follows the frame control field. A final stretch of random mixed traffic moves the levels through both interrupt thresholds while the interrupt enable changes. All of this runs against a queue-based model that is compared every cycle.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  localparam int ADDR_W = 12;

  // register offsets inside the 4 KB window
  localparam logic [ADDR_W-1:0] OFF_FRAME = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_MODE  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_DATA  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_DIV   = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_MSK   = 12'h01C;
  localparam logic [ADDR_W-1:0] OFF_XFER  = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_IDBLK = 12'hFE0;

  // status bit positions
  localparam int ST_TXE  = 0;
  localparam int ST_TXNF = 1;
  localparam int ST_RXNE = 2;
  localparam int ST_RXF  = 3;
  localparam int ST_BUSY = 4;

  // raw interrupt bit positions
  localparam int IRQ_RXW = 2;
  localparam int IRQ_TXW = 3;

  typedef enum logic [3:0] {
    RG_FRAME, RG_MODE, RG_DATA, RG_STAT, RG_DIV,
    RG_IEN, RG_RAW, RG_MSK, RG_XFER, RG_ID, RG_NONE
  } reg_sel_e;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h22;
      3'd1:    return 8'h10;
      3'd2:    return 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/ssp_addr_dec.sv
module ssp_addr_dec
  import ssp_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    sel = RG_NONE;
    if (addr[1:0] == 2'b00) begin
      if (addr >= OFF_IDBLK) begin
        sel = RG_ID;
      end else begin
        case (addr)
          OFF_FRAME: sel = RG_FRAME;
          OFF_MODE:  sel = RG_MODE;
          OFF_DATA:  sel = RG_DATA;
          OFF_STAT:  sel = RG_STAT;
          OFF_DIV:   sel = RG_DIV;
          OFF_IEN:   sel = RG_IEN;
          OFF_RAW:   sel = RG_RAW;
          OFF_MSK:   sel = RG_MSK;
          OFF_XFER:  sel = RG_XFER;
          default:   sel = RG_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] level
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  always_comb begin
    do_push  = push && (cnt_q != FULL_LVL);
    do_pop   = pop && (cnt_q != '0);
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
  end

  assign head  = (cnt_q == '0) ? '0 : mem[rd_ptr_q];
  assign level = cnt_q;

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == FULL_LVL && push && !pop) |=> (level == FULL_LVL));

  // R11
  both_ways_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && level != '0 && level != FULL_LVL) |=> $stable(level));

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && pop && !push) |=> (level == '0));

endmodule

// File: rtl/ssp_status.sv
module ssp_status
  import ssp_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] tx_lvl,
  input  logic [CW-1:0] rx_lvl,
  input  logic [3:0]    ien,
  output logic [4:0]    stat,
  output logic [3:0]    raw,
  output logic          irq
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_LVL = CW'(DEPTH / 2);

  always_comb begin
    stat          = '0;
    stat[ST_TXE]  = (tx_lvl == '0);
    stat[ST_TXNF] = (tx_lvl != FULL_LVL);
    stat[ST_RXNE] = (rx_lvl != '0);
    stat[ST_RXF]  = (rx_lvl == FULL_LVL);
    stat[ST_BUSY] = (tx_lvl != '0);
    raw           = '0;
    raw[IRQ_RXW]  = (rx_lvl >= HALF_LVL);
    raw[IRQ_TXW]  = (tx_lvl <= HALF_LVL);
    irq           = |(raw & ien);
  end

endmodule

// File: rtl/ssp_regfile.sv
module ssp_regfile
  import ssp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_err,
  output logic              irq,
  output logic [3:0]        port_mode,
  input  logic              tx_pop,
  output logic [DW-1:0]     tx_data,
  output logic              tx_valid,
  input  logic              rx_push,
  input  logic [DW-1:0]     rx_data,
  output logic              rx_ready
);

  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  reg_sel_e      sel;
  logic          wr_acc, rd_acc;
  logic [DW-1:0] frame_q, frame_d;
  logic [3:0]    mode_q, mode_d;
  logic [7:0]    div_q, div_d;
  logic [3:0]    ien_q, ien_d;
  logic          err_q, err_d;
  logic [DW-1:0] fmask;
  logic [CW-1:0] tx_lvl, rx_lvl;
  logic [DW-1:0] rx_head;
  logic [4:0]    stat;
  logic [3:0]    raw;

  ssp_addr_dec u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_acc = bus_en && bus_we;
  assign rd_acc = bus_en && !bus_we;
  assign fmask  = DW'((32'd2 << frame_q[3:0]) - 32'd1);

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_acc && sel == RG_DATA),
    .push_data (bus_wdata & fmask),
    .pop       (tx_pop),
    .head      (tx_data),
    .level     (tx_lvl)
  );

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_push),
    .push_data (rx_data),
    .pop       (rd_acc && sel == RG_DATA),
    .head      (rx_head),
    .level     (rx_lvl)
  );

  ssp_status #(.DEPTH(DEPTH)) u_stat (
    .tx_lvl (tx_lvl),
    .rx_lvl (rx_lvl),
    .ien    (ien_q),
    .stat   (stat),
    .raw    (raw),
    .irq    (irq)
  );

  // register next state
  always_comb begin
    frame_d = frame_q;
    mode_d  = mode_q;
    div_d   = div_q;
    ien_d   = ien_q;
    err_d   = bus_en && (sel == RG_NONE);
    if (wr_acc) begin
      case (sel)
        RG_FRAME: frame_d = bus_wdata;
        RG_MODE:  mode_d  = bus_wdata[3:0];
        RG_DIV:   div_d   = bus_wdata[7:0];
        RG_IEN:   ien_d   = bus_wdata[3:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      mode_q  <= '0;
      div_q   <= '0;
      ien_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      frame_q <= frame_d;
      mode_q  <= mode_d;
      div_q   <= div_d;
      ien_q   <= ien_d;
      err_q   <= err_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      case (sel)
        RG_FRAME: bus_rdata = frame_q;
        RG_MODE:  bus_rdata = DW'(mode_q);
        RG_DATA:  bus_rdata = rx_head;
        RG_STAT:  bus_rdata = DW'(stat);
        RG_DIV:   bus_rdata = DW'(div_q);
        RG_IEN:   bus_rdata = DW'(ien_q);
        RG_RAW:   bus_rdata = DW'(raw);
        RG_MSK:   bus_rdata = DW'(raw & ien_q);
        RG_ID:    bus_rdata = DW'(id_byte(bus_addr[4:2]));
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign bus_err   = err_q;
  assign port_mode = mode_q;
  assign tx_valid  = (tx_lvl != '0);
  assign rx_ready  = (rx_lvl != FULL_LVL);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_en));

  // R9
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata != '0) |-> rd_acc);

  // R7
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != '0));

  // R5
  busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid == stat[ST_BUSY]);

  // R3
  tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat[ST_TXNF] && wr_acc && sel == RG_DATA && !tx_pop) |=> !stat[ST_TXNF]);

endmodule

// File: tb/ssp_regfile_tb.sv
module ssp_regfile_tb;

  logic        clk;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [11:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_err, irq;
  logic [3:0]  port_mode;
  logic        tx_pop, tx_valid;
  logic [15:0] tx_data;
  logic        rx_push, rx_ready;
  logic [15:0] rx_data;

  ssp_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq(irq), .port_mode(port_mode),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_valid(tx_valid),
    .rx_push(rx_push), .rx_data(rx_data), .rx_ready(rx_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // reference model state
  int    txq[$];
  int    rxq[$];
  int    m_frame, m_mode, m_div, m_ien;
  bit    m_err;
  int    vectors, fails;
  string phase;
  bit    done;

  function automatic bit mapped(input int a);
    if ((a & 3) != 0) return 0;
    if (a >= 'hFE0) return 1;
    return (a <= 'h20);
  endfunction

  function automatic int raw_val();
    int r = 0;
    if (rxq.size() >= 4) r |= 4;
    if (txq.size() <= 4) r |= 8;
    return r;
  endfunction

  function automatic int stat_val();
    int s = 0;
    if (txq.size() == 0) s |= 1;
    if (txq.size() != 8) s |= 2;
    if (rxq.size() != 0) s |= 4;
    if (rxq.size() == 8) s |= 8;
    if (txq.size() != 0) s |= 16;
    return s;
  endfunction

  function automatic int exp_read(input int a);
    int ids[8] = '{'h22, 'h10, 'h04, 'h00, 'h0D, 'hF0, 'h05, 'hB1};
    if (!mapped(a)) return 0;
    if (a >= 'hFE0) return ids[(a - 'hFE0) >> 2];
    case (a)
      'h00: return m_frame;
      'h04: return m_mode;
      'h08: return (rxq.size() != 0) ? rxq[0] : 0;
      'h0C: return stat_val();
      'h10: return m_div;
      'h14: return m_ien;
      'h18: return raw_val();
      'h1C: return raw_val() & m_ien;
      default: return 0;
    endcase
  endfunction

  function automatic string read_tag(input int a);
    if (!mapped(a) || a == 'h20) return "R9";
    if (a >= 'hFE0) return "R8";
    case (a)
      'h08: return "R4";
      'h0C: return "R5";
      'h18, 'h1C: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic miss(input string req, input string what, input int act, input int exp);
    fails++;
    $display("FAIL %s [%s] %s: actual %h expected %h", req, phase, what, act, exp);
  endtask

  task automatic compare(input bit en, input bit we, input int a);
    int exp_rd;
    vectors++;
    exp_rd = (en && !we) ? exp_read(a) : 0;
    if (int'(bus_rdata) != exp_rd) miss(read_tag(a), "bus_rdata", bus_rdata, exp_rd);
    if (tx_valid != (txq.size() != 0)) miss("R2", "tx_valid", tx_valid, txq.size() != 0);
    if (txq.size() != 0 && int'(tx_data) != txq[0]) miss("R2", "tx_data", tx_data, txq[0]);
    if (rx_ready != (rxq.size() < 8)) miss("R4", "rx_ready", rx_ready, rxq.size() < 8);
    if (irq != ((raw_val() & m_ien) != 0)) miss("R7", "irq", irq, (raw_val() & m_ien) != 0);
    if (int'(port_mode) != m_mode) miss("R1", "port_mode", port_mode, m_mode);
    if (bus_err != m_err) miss("R9", "bus_err", bus_err, m_err);
  endtask

  task automatic model_edge(input bit en, input bit we, input int a, input int wd,
                            input bit tp, input bit rp, input int rd);
    bit tx_room = txq.size() < 8;
    bit tx_any  = txq.size() != 0;
    bit rx_room = rxq.size() < 8;
    bit rx_any  = rxq.size() != 0;
    m_err = en && !mapped(a);
    if (en && we && mapped(a)) begin
      case (a)
        'h00: m_frame = wd & 'hFFFF;
        'h04: m_mode  = wd & 'hF;
        'h10: m_div   = wd & 'hFF;
        'h14: m_ien   = wd & 'hF;
        default: ;
      endcase
    end
    if (tp && tx_any) void'(txq.pop_front());
    if (en && we && a == 'h08 && tx_room)
      txq.push_back(wd & ((2 << (m_frame & 'hF)) - 1));
    if (en && !we && a == 'h08 && rx_any) void'(rxq.pop_front());
    if (rp && rx_room) rxq.push_back(rd);
  endtask

  task automatic cyc(input bit en, input bit we, input int a, input int wd,
                     input bit tp, input bit rp, input int rd);
    bus_en = en; bus_we = we; bus_addr = a[11:0]; bus_wdata = wd[15:0];
    tx_pop = tp; rx_push = rp; rx_data = rd[15:0];
    #2;
    compare(en, we, a);
    @(posedge clk);
    if (rst_n) model_edge(en, we, a, wd, tp, rp, rd);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    cyc(1, 1, a, d, 0, 0, 0);
  endtask

  task automatic rd(input int a);
    cyc(1, 0, a, 0, 0, 0, 0);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int addrs[16] = '{'h00, 'h04, 'h08, 'h08, 'h08, 'h0C, 'h10, 'h14,
                      'h18, 'h1C, 'h20, 'h24, 'hFE0, 'hFF8, 'h0A, 'h300};
    vectors = 0; fails = 0; done = 0;
    m_frame = 0; m_mode = 0; m_div = 0; m_ien = 0; m_err = 0;
    rst_n = 1'b0;
    bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    tx_pop = 0; rx_push = 0; rx_data = '0;
    @(negedge clk);

    // R10: reset state, during and just after reset
    phase = "R10";
    idle(); idle();
    rst_n = 1'b1;
    for (int a = 0; a <= 'h20; a += 4) rd(a);

    // R1: writable registers read back
    phase = "R1";
    wr('h00, 'hBEEF); rd('h00);
    wr('h04, 'hFFF5); rd('h04);
    wr('h04, 'h000A); rd('h04);
    wr('h10, 'h01FF); rd('h10);
    wr('h10, 'h005A); rd('h10);
    wr('h14, 'h0003); rd('h14);
    wr('h14, 'h0000);

    // R2: frame masking and FIFO order to the engine
    phase = "R2";
    wr('h00, 7);  wr('h08, 'hABCD);
    wr('h00, 3);  wr('h08, 'h1234);
    wr('h00, 15); wr('h08, 'hFFFF);
    wr('h00, 0);  wr('h08, 'hFFFF);
    rd('h0C);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 0, 0);

    // R3: overfill the transmit queue
    phase = "R3";
    wr('h00, 15);
    for (int i = 0; i < 9; i++) wr('h08, 'h100 + i);
    rd('h0C); rd('h18);
    cyc(1, 1, 'h08, 'h5555, 1, 0, 0);
    rd('h0C);
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, 0, 1, 0, 0);
    rd('h0C);

    // R4: receive queue fill and drain, empty read
    phase = "R4";
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, 0, 0, 1, 'hA0 + i);
    rd('h0C);
    for (int i = 0; i < 10; i++) rd('h08);
    rd('h0C);

    // R6 / R7: thresholds against the interrupt enable
    phase = "R6";
    wr('h14, 'hC);
    rd('h18); rd('h1C);
    for (int i = 0; i < 5; i++) begin
      wr('h08, i); cyc(0, 0, 0, 0, 0, 1, 'h77 + i); rd('h18); rd('h1C);
    end
    phase = "R7";
    wr('h14, 'h4); idle();
    wr('h14, 'h8); idle();
    wr('h14, 'h3); idle();
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 0, 0, 1, 0, 0); rd('h08);
    end

    // R8: identification block
    phase = "R8";
    for (int a = 'hFE0; a <= 'hFFC; a += 4) rd(a);
    wr('hFE4, 'h99); rd('hFE4);

    // R9: undecoded and read-only accesses
    phase = "R9";
    rd('h24); idle();
    wr('h800, 'h1234); idle(); idle();
    rd('hFE2); rd('h006); wr('h005, 'hF);
    rd('h04);
    wr('h20, 'hFFFF); rd('h20);
    wr('h0C, 'hFFFF); wr('h18, 'hF); wr('h1C, 'hF); rd('h0C);

    // R11: simultaneous push and pop on both queues
    phase = "R11";
    cyc(1, 1, 'h08, 'h11, 1, 0, 0);
    rd('h0C);
    for (int i = 0; i < 4; i++) wr('h08, 'h20 + i);
    cyc(1, 1, 'h08, 'h33, 1, 0, 0); rd('h18);
    for (int i = 0; i < 4; i++) wr('h08, 'h40 + i);
    cyc(1, 1, 'h08, 'h55, 1, 0, 0); rd('h0C);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 1, 'hC0 + i);
    cyc(1, 0, 'h08, 0, 0, 1, 'hD0); rd('h18);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 1, 'hE0 + i);
    cyc(1, 0, 'h08, 0, 0, 1, 'hF0); rd('h0C);
    for (int i = 0; i < 9; i++) rd('h08);

    // mixed random traffic across all requirements
    phase = "mix";
    for (int i = 0; i < 2000; i++) begin
      int a = addrs[$urandom_range(0, 15)];
      bit en = ($urandom_range(0, 3) != 0);
      bit we = $urandom_range(0, 1);
      cyc(en, we, a, $urandom_range(0, 'hFFFF), $urandom_range(0, 2) == 0,
          $urandom_range(0, 2) == 0, $urandom_range(0, 'hFFFF));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule